// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block monitors 24 external input lines that are already synchronous to its clock. Each line has its own 4-bit trigger code that selects a level or edge condition. When the condition is met, the line's pending flag is set. A per-line mask decides which pending flags reach the outputs. The active flags are then gathered onto six parent interrupt outputs that feed a downstream interrupt controller.

Software reaches the block over a plain 32-bit register bus. The bus has a strobe, a write enable, a byte address and write data, and read data is returned combinationally. Four trigger registers hold the codes, eight codes per register. One register holds the mask bits. A write-one-to-clear register holds the pending flags.

The parameter `DIRECT_LOW` selects how the four lowest lines are handled:

- When `DIRECT_LOW` is 1, lines 0 to 3 bypass the pending and mask logic. Their detected condition, delayed by one register, drives parent outputs 0 to 3 directly.
- When `DIRECT_LOW` is 0 (the default), lines 0 to 3 are latched and masked like every other line.

Top module: `extint_ctrl`

## Requirements
- R1: While reset is held and on leaving it, every trigger code reads 0, the mask register reads 0x00FFFFFF, the pending register reads 0 and all six parent outputs are low.
- R2: The trigger code of line i sits at byte address 0x88 + 4·(i/8), bits [4·(i mod 8)+3 : 4·(i mod 8)], and reads back as written. The fourth trigger register at 0x94 always reads zero.
- R3: Code 4 (rising edge) sets the line's pending flag at the clock edge where the input is 1 after being 0 at the previous edge, and at no other time.
- R4: Code 2 (falling edge) sets the pending flag at the clock edge where the input is 0 after being 1 at the previous edge.
- R5: Code 6 sets the pending flag on either edge of the input.
- R6: Code 1 (high level) or code 0 (low level) sets the pending flag at every edge where the input is at the active level. A clear therefore sticks only once the input has left that level.
- R7: Codes 3, 5, 7 and 8 to 15 never set the pending flag.
- R8: Writing the pending register at 0xA8 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. If a new event on a line arrives in the same cycle as its clear, the event wins.
- R9: The mask register sits at 0xA4, and bit i belongs to line i. A 1 keeps line i off the parent outputs, but the pending flag is still captured. Bits 31:24 read zero.
- R10: Parent output 4 is high while any of lines 4 to 7 is both pending and unmasked. Parent output 5 does the same for lines 8 to 23.
- R11: With `DIRECT_LOW` = 0, parent output k (k = 0 to 3) is high while line k is both pending and unmasked.
- R12: With `DIRECT_LOW` = 1, parent output k (k = 0 to 3) equals line k's detected condition delayed by one clock. In this mode the mask has no effect on these outputs, and pending bits 3:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, valid with bus_en |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| line_in | input | 24 | External interrupt lines, synchronous to clk |
| parent_irq | output | 6 | Parent interrupt outputs |

## Verification
The assertions check on every cycle that:

- every detected condition on a latched line sets its pending flag at the next edge;
- a clear with no coincident event removes the flag;
- a fully masked upper group keeps parent output 5 low;
- in direct mode, outputs 0 to 3 follow the detected condition one cycle late.

The exact encoding of each trigger code, the register layout and readback, and the distinct behaviour of edge and level codes under a clear can only be shown by the bench's scenarios. The bench sweeps every code on every line with a fixed input pattern and predicts the pending word arithmetically.

// File: rtl/extint_pkg.sv
// Shared constants and types for the external interrupt trigger controller.
// Assumes the line count fits into one bus data word.
package extint_pkg;
    localparam int NUM_LINES    = 24;
    localparam int DIRECT_LINES = 4;
    localparam int SPLIT_LINE   = 8;
    localparam int NUM_PARENTS  = DIRECT_LINES + 2;
    localparam int FIELD_W      = 4;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 8;
    localparam int TRIG_REGS    = 4;

    localparam logic [ADDR_W-1:0] TRIG_BASE = 8'h88;
    localparam logic [ADDR_W-1:0] MASK_ADDR = 8'hA4;
    localparam logic [ADDR_W-1:0] PEND_ADDR = 8'hA8;

    // Trigger codes; any other value means no trigger
    typedef enum logic [FIELD_W-1:0] {
        TRG_LOW  = 4'd0,
        TRG_HIGH = 4'd1,
        TRG_FALL = 4'd2,
        TRG_RISE = 4'd4,
        TRG_BOTH = 4'd6
    } trig_code_e;
endpackage

// File: rtl/extint_regs.sv
// Register file: trigger codes, mask bits, pending-clear strobe and read mux.
// Assumes single-cycle bus writes and a combinational read path.
module extint_regs #(
    parameter int NUM_LINES = extint_pkg::NUM_LINES,
    parameter int FIELD_W   = extint_pkg::FIELD_W,
    parameter int DATA_W    = extint_pkg::DATA_W,
    parameter int ADDR_W    = extint_pkg::ADDR_W,
    parameter int TRIG_REGS = extint_pkg::TRIG_REGS,
    parameter logic [ADDR_W-1:0] TRIG_BASE = extint_pkg::TRIG_BASE,
    parameter logic [ADDR_W-1:0] MASK_ADDR = extint_pkg::MASK_ADDR,
    parameter logic [ADDR_W-1:0] PEND_ADDR = extint_pkg::PEND_ADDR
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_en,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic [NUM_LINES-1:0]         pend_q,
    output logic [NUM_LINES*FIELD_W-1:0] trig_cfg,
    output logic [NUM_LINES-1:0]         mask_q,
    output logic [NUM_LINES-1:0]         pend_clr,
    output logic [DATA_W-1:0]            bus_rdata
);
    localparam int FPR       = DATA_W / FIELD_W;
    localparam int ADDR_STEP = DATA_W / 8;

    logic wr_en;
    assign wr_en = bus_en & bus_we;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_field
        localparam int REG_IDX = l / FPR;
        localparam int SLOT    = l % FPR;
        localparam logic [ADDR_W-1:0] FIELD_ADDR = TRIG_BASE + ADDR_W'(REG_IDX * ADDR_STEP);
        logic [FIELD_W-1:0] field_q;

        // Hold the trigger code of this line
        always_ff @(posedge clk) begin
            if (!rst_n)
                field_q <= '0;
            else if (wr_en && bus_addr == FIELD_ADDR)
                field_q <= bus_wdata[SLOT*FIELD_W +: FIELD_W];
        end

        assign trig_cfg[l*FIELD_W +: FIELD_W] = field_q;
    end

    // Hold the mask bits, all lines masked after reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (wr_en && bus_addr == MASK_ADDR)
            mask_q <= bus_wdata[NUM_LINES-1:0];
    end

    // Turn a pending-register write into a per-line clear strobe
    always_comb begin
        pend_clr = '0;
        if (wr_en && bus_addr == PEND_ADDR)
            pend_clr = bus_wdata[NUM_LINES-1:0];
    end

    // Select read data by address
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == MASK_ADDR) begin
            bus_rdata[NUM_LINES-1:0] = mask_q;
        end else if (bus_addr == PEND_ADDR) begin
            bus_rdata[NUM_LINES-1:0] = pend_q;
        end else begin
            for (int r = 0; r < TRIG_REGS; r++) begin
                if (bus_addr == TRIG_BASE + ADDR_W'(r * ADDR_STEP)) begin
                    for (int k = 0; k < FPR; k++) begin
                        if (r * FPR + k < NUM_LINES)
                            bus_rdata[k*FIELD_W +: FIELD_W] = trig_cfg[(r*FPR+k)*FIELD_W +: FIELD_W];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/extint_detect.sv
// Per-line trigger detection: compares each input against its previous
// sample and decodes the line's trigger code into a one-cycle event.
// Assumes inputs are synchronous; unknown codes produce no event.
module extint_detect #(
    parameter int NUM_LINES = extint_pkg::NUM_LINES,
    parameter int FIELD_W   = extint_pkg::FIELD_W
) (
    input  logic                         clk,
    input  logic [NUM_LINES-1:0]         line_in,
    input  logic [NUM_LINES*FIELD_W-1:0] trig_cfg,
    output logic [NUM_LINES-1:0]         line_evt
);
    import extint_pkg::*;

    logic [NUM_LINES-1:0] prev_q;

    // Keep the previous sample; it also tracks during reset so no false edge follows
    always_ff @(posedge clk) begin
        prev_q <= line_in;
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [FIELD_W-1:0] code;
        logic cur, old;
        assign code = trig_cfg[l*FIELD_W +: FIELD_W];
        assign cur  = line_in[l];
        assign old  = prev_q[l];

        // Decode the trigger code into an event for this cycle
        always_comb begin
            case (code)
                FIELD_W'(TRG_LOW):  line_evt[l] = ~cur;
                FIELD_W'(TRG_HIGH): line_evt[l] = cur;
                FIELD_W'(TRG_FALL): line_evt[l] = old & ~cur;
                FIELD_W'(TRG_RISE): line_evt[l] = ~old & cur;
                FIELD_W'(TRG_BOTH): line_evt[l] = old ^ cur;
                default:            line_evt[l] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/extint_pending.sv
// Pending capture: latches events per line, with write-one-to-clear that
// loses to a coincident event. In direct mode the lowest lines skip the
// latch and only register the event for one cycle.
module extint_pending #(
    parameter int NUM_LINES    = extint_pkg::NUM_LINES,
    parameter int DIRECT_LINES = extint_pkg::DIRECT_LINES,
    parameter bit DIRECT_LOW   = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_LINES-1:0]    line_evt,
    input  logic [NUM_LINES-1:0]    pend_clr,
    output logic [NUM_LINES-1:0]    pend_q,
    output logic [DIRECT_LINES-1:0] direct_q
);
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_pend
        if (DIRECT_LOW && l < DIRECT_LINES) begin : g_bypass
            assign pend_q[l] = 1'b0;
        end else begin : g_latch
            logic flag_q;

            // Set on event, clear on strobe; the event wins a tie
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else
                    flag_q <= (flag_q & ~pend_clr[l]) | line_evt[l];
            end

            assign pend_q[l] = flag_q;
        end
    end

    for (genvar d = 0; d < DIRECT_LINES; d++) begin : g_direct
        if (DIRECT_LOW) begin : g_reg
            logic evt_q;

            // Register the raw event for the dedicated output
            always_ff @(posedge clk) begin
                if (!rst_n)
                    evt_q <= 1'b0;
                else
                    evt_q <= line_evt[d];
            end

            assign direct_q[d] = evt_q;
        end else begin : g_none
            assign direct_q[d] = 1'b0;
        end
    end
endmodule

// File: rtl/extint_route.sv
// Output aggregation: dedicated outputs for the lowest lines, one shared
// output for the middle group and one for the upper group.
// Assumes DIRECT_LINES < SPLIT_LINE < NUM_LINES.
module extint_route #(
    parameter int NUM_LINES    = extint_pkg::NUM_LINES,
    parameter int DIRECT_LINES = extint_pkg::DIRECT_LINES,
    parameter int SPLIT_LINE   = extint_pkg::SPLIT_LINE,
    parameter bit DIRECT_LOW   = 1'b0
) (
    input  logic [NUM_LINES-1:0]    pend_q,
    input  logic [NUM_LINES-1:0]    mask_q,
    input  logic [DIRECT_LINES-1:0] direct_q,
    output logic [DIRECT_LINES+1:0] parent_irq
);
    logic [NUM_LINES-1:0] live;
    assign live = pend_q & ~mask_q;

    for (genvar d = 0; d < DIRECT_LINES; d++) begin : g_ded
        assign parent_irq[d] = DIRECT_LOW ? direct_q[d] : live[d];
    end

    assign parent_irq[DIRECT_LINES]   = |live[SPLIT_LINE-1:DIRECT_LINES];
    assign parent_irq[DIRECT_LINES+1] = |live[NUM_LINES-1:SPLIT_LINE];
endmodule

// File: rtl/extint_ctrl.sv
// External interrupt trigger controller top level: register file,
// detectors, pending capture and output routing.
// Assumes line_in is already synchronous to clk.
module extint_ctrl #(
    parameter bit DIRECT_LOW   = 1'b0,
    parameter int NUM_LINES    = extint_pkg::NUM_LINES,
    parameter int DIRECT_LINES = extint_pkg::DIRECT_LINES,
    parameter int SPLIT_LINE   = extint_pkg::SPLIT_LINE,
    parameter int FIELD_W      = extint_pkg::FIELD_W,
    parameter int DATA_W       = extint_pkg::DATA_W,
    parameter int ADDR_W       = extint_pkg::ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NUM_LINES-1:0]    line_in,
    output logic [DIRECT_LINES+1:0] parent_irq
);
    logic [NUM_LINES*FIELD_W-1:0] trig_cfg;
    logic [NUM_LINES-1:0]         mask_q;
    logic [NUM_LINES-1:0]         pend_clr;
    logic [NUM_LINES-1:0]         pend_q;
    logic [NUM_LINES-1:0]         line_evt;
    logic [DIRECT_LINES-1:0]      direct_q;

    extint_regs #(
        .NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_q(pend_q),
        .trig_cfg(trig_cfg), .mask_q(mask_q), .pend_clr(pend_clr),
        .bus_rdata(bus_rdata)
    );

    extint_detect #(
        .NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W)
    ) u_detect (
        .clk(clk), .line_in(line_in), .trig_cfg(trig_cfg), .line_evt(line_evt)
    );

    extint_pending #(
        .NUM_LINES(NUM_LINES), .DIRECT_LINES(DIRECT_LINES), .DIRECT_LOW(DIRECT_LOW)
    ) u_pending (
        .clk(clk), .rst_n(rst_n), .line_evt(line_evt), .pend_clr(pend_clr),
        .pend_q(pend_q), .direct_q(direct_q)
    );

    extint_route #(
        .NUM_LINES(NUM_LINES), .DIRECT_LINES(DIRECT_LINES),
        .SPLIT_LINE(SPLIT_LINE), .DIRECT_LOW(DIRECT_LOW)
    ) u_route (
        .pend_q(pend_q), .mask_q(mask_q), .direct_q(direct_q), .parent_irq(parent_irq)
    );
endmodule

// File: rtl/extint_ctrl_chk.sv
// Property checker for the external interrupt trigger controller,
// attached to every instance of the top module by bind.
module extint_ctrl_chk #(
    parameter bit DIRECT_LOW   = 1'b0,
    parameter int NUM_LINES    = extint_pkg::NUM_LINES,
    parameter int DIRECT_LINES = extint_pkg::DIRECT_LINES,
    parameter int SPLIT_LINE   = extint_pkg::SPLIT_LINE,
    parameter int ADDR_W       = extint_pkg::ADDR_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_en,
    input logic                    bus_we,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [NUM_LINES-1:0]    clr_data,
    input logic [NUM_LINES-1:0]    line_evt,
    input logic [NUM_LINES-1:0]    pend_q,
    input logic [NUM_LINES-1:0]    mask_q,
    input logic [DIRECT_LINES+1:0] parent_irq
);
    localparam int FIRST_LATCHED = DIRECT_LOW ? DIRECT_LINES : 0;

    logic clr_wr;
    assign clr_wr = bus_en && bus_we && bus_addr == extint_pkg::PEND_ADDR;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> parent_irq == '0);

    // R9
    upper_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q[NUM_LINES-1:SPLIT_LINE]) |-> !parent_irq[DIRECT_LINES+1]);

    for (genvar l = FIRST_LATCHED; l < NUM_LINES; l++) begin : g_lat
        // R3
        event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            line_evt[l] |=> pend_q[l]);

        // R8
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_data[l] && !line_evt[l]) |=> !pend_q[l]);
    end

    if (DIRECT_LOW) begin : g_dir
        for (genvar d = 0; d < DIRECT_LINES; d++) begin : g_out
            // R12
            direct_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
                line_evt[d] |=> parent_irq[d]);

            // R12
            direct_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !line_evt[d] |=> !parent_irq[d]);
        end
    end
endmodule

bind extint_ctrl extint_ctrl_chk #(
    .DIRECT_LOW(DIRECT_LOW), .NUM_LINES(NUM_LINES), .DIRECT_LINES(DIRECT_LINES),
    .SPLIT_LINE(SPLIT_LINE), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .clr_data(bus_wdata[NUM_LINES-1:0]), .line_evt(line_evt), .pend_q(pend_q),
    .mask_q(mask_q), .parent_irq(parent_irq)
);

// File: tb/extint_ctrl_test.sv
// Self-checking bench: a latched-mode instance and a direct-mode instance
// share one stimulus; every trigger code is swept on every line.
module extint_ctrl_test;
    localparam logic [7:0] TB = 8'h88;
    localparam logic [7:0] MA = 8'hA4;
    localparam logic [7:0] PA = 8'hA8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] rd_l, rd_d;
    logic [23:0] line_in = 24'hFFFFFF;
    logic [5:0]  irq_l, irq_d;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    extint_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_l), .line_in(line_in), .parent_irq(irq_l)
    );

    extint_ctrl #(.DIRECT_LOW(1'b1)) uut_direct (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_d), .line_in(line_in), .parent_irq(irq_d)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] dl, output logic [31:0] dd);
        @(negedge clk);
        bus_addr = a;
        #1;
        dl = rd_l; dd = rd_d;
    endtask

    // Code cdef on every line, code c on line sel (sel < 0: none)
    task automatic set_codes(input int sel, input logic [3:0] c, input logic [3:0] cdef);
        for (int r = 0; r < 3; r++) begin
            logic [31:0] v;
            v = {8{cdef}};
            if (sel >= 0 && sel / 8 == r) v[(sel % 8) * 4 +: 4] = c;
            wr(TB + 8'(4 * r), v);
        end
    endtask

    function automatic string tag_of(input int c);
        case (c)
            0, 1:    return "R6";
            2:       return "R4";
            4:       return "R3";
            6:       return "R5";
            default: return "R7";
        endcase
    endfunction

    function automatic int parent_of(input int i);
        return (i < 4) ? i : ((i < 8) ? 4 : 5);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] dl, dd, ea, eb, ec, ed;
        repeat (3) @(posedge clk);
        // R1: state while reset is held
        for (int r = 0; r < 4; r++) begin
            rd(TB + 8'(4 * r), dl, dd);
            check("R1 trig", dl, 32'h0);
        end
        rd(MA, dl, dd); check("R1 mask", dl, 32'h00FFFFFF);
        rd(PA, dl, dd); check("R1 pend", dl, 32'h0);
        check("R1 irq", {26'h0, irq_l}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd(PA, dl, dd); check("R1 pend after", dl, 32'h0);
        check("R1 irq after", {26'h0, irq_l | irq_d}, 32'h0);

        // R2: layout and readback
        wr(TB, 32'h76543210); wr(TB + 8'd4, 32'hFEDCBA98); wr(TB + 8'd8, 32'h0F1E2D3C);
        wr(TB + 8'd12, 32'hFFFFFFFF);
        rd(TB, dl, dd);         check("R2 reg0", dl, 32'h76543210);
        rd(TB + 8'd4, dl, dd);  check("R2 reg1", dl, 32'hFEDCBA98);
        rd(TB + 8'd8, dl, dd);  check("R2 reg2", dl, 32'h0F1E2D3C);
        rd(TB + 8'd12, dl, dd); check("R2 reg3", dl, 32'h0);
        wr(MA, 32'hFFFFFFFF);
        rd(MA, dl, dd); check("R9 mask width", dl, 32'h00FFFFFF);

        // Sweep every code on every line, all lines masked
        set_codes(-1, 4'd0, 4'd3);
        line_in = 24'h0;
        for (int i = 0; i < 24; i++) begin
            for (int c = 0; c < 16; c++) begin
                set_codes(i, 4'(c), 4'd3);
                wr(PA, 32'h00FFFFFF);
                rd(PA, dl, dd);
                ea = (c == 0) ? (32'd1 << i) : 32'd0;
                check(tag_of(c), dl, ea);
                @(negedge clk) line_in[i] = 1'b1;
                rd(PA, dl, dd);
                eb = ea | ((c == 1 || c == 4 || c == 6) ? (32'd1 << i) : 32'd0);
                check(tag_of(c), dl, eb);
                check("R9 masked irq", {26'h0, irq_l}, 32'h0);
                wr(PA, 32'h00FFFFFF);
                rd(PA, dl, dd);
                ec = (c == 1) ? (32'd1 << i) : 32'd0;
                check((c == 1) ? "R6" : "R8", dl, ec);
                @(negedge clk) line_in[i] = 1'b0;
                rd(PA, dl, dd);
                ed = ec | ((c == 0 || c == 2 || c == 6) ? (32'd1 << i) : 32'd0);
                check(tag_of(c), dl, ed);
            end
        end

        // Routing, all unmasked, rising edges
        set_codes(-1, 4'd0, 4'd4);
        wr(MA, 32'h0);
        wr(PA, 32'h00FFFFFF);
        for (int i = 0; i < 24; i++) begin
            logic [31:0] oh;
            oh = 32'd1 << parent_of(i);
            @(negedge clk) line_in[i] = 1'b1;
            @(negedge clk); #1;
            check((i < 4) ? "R11" : "R10", {26'h0, irq_l}, oh);
            check((i < 4) ? "R12" : "R10", {26'h0, irq_d}, oh);
            @(negedge clk); #1;
            check((i < 4) ? "R11 sticky" : "R10 sticky", {26'h0, irq_l}, oh);
            check((i < 4) ? "R12 pulse" : "R10 sticky", {26'h0, irq_d}, (i < 4) ? 32'h0 : oh);
            rd(PA, dl, dd);
            check("R3 route pend", dl, 32'd1 << i);
            check("R12 pend low", dd & 32'hF, 32'h0);
            line_in[i] = 1'b0;
            wr(PA, 32'd1 << i);
            @(negedge clk); #1;
            check("R8 cleared irq", {26'h0, irq_l}, 32'h0);
        end

        // Masking and write-one-to-clear details
        @(negedge clk) begin line_in[5] = 1'b1; line_in[9] = 1'b1; end
        @(negedge clk) begin line_in[5] = 1'b0; line_in[9] = 1'b0; end
        wr(MA, 32'h200);
        @(negedge clk); #1;
        check("R9 group mask", {26'h0, irq_l}, 32'h10);
        rd(MA, dl, dd); check("R9 readback", dl, 32'h200);
        rd(PA, dl, dd); check("R9 captured", dl, 32'h220);
        wr(PA, 32'h0);
        rd(PA, dl, dd); check("R8 zero write", dl, 32'h220);
        wr(PA, 32'h20);
        rd(PA, dl, dd); check("R8 one bit", dl, 32'h200);
        check("R9 all gated", {26'h0, irq_l}, 32'h0);
        wr(MA, 32'h0);
        @(negedge clk); #1;
        check("R9 unmask", {26'h0, irq_l}, 32'h20);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = PA; bus_wdata = 32'h00FFFFFF;
        line_in[10] = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; line_in[10] = 1'b0;
        rd(PA, dl, dd); check("R8 event wins", dl, 32'h400);
        wr(PA, 32'h00FFFFFF);

        // Direct mode ignores the mask on the low lines
        wr(MA, 32'h00FFFFFF);
        set_codes(1, 4'd1, 4'd3);
        @(negedge clk) line_in[1] = 1'b1;
        @(negedge clk); #1;
        check("R12 level on", {26'h0, irq_d}, 32'h2);
        check("R9 latched gated", {26'h0, irq_l}, 32'h0);
        @(negedge clk); #1;
        check("R12 level holds", {26'h0, irq_d}, 32'h2);
        @(negedge clk) line_in[1] = 1'b0;
        @(negedge clk); #1;
        check("R12 level off", {26'h0, irq_d}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule